// File: doc/BRIEF.md
# Processor-Side Packet Port with Word Packing

This block sits between a 40-bit processor and a byte-wide packet network. Its outbound half takes whole processor words and stores them. It does not release any byte of a packet onto the network until the processor has written the packet's last word. Each word then leaves as five network bytes, most significant byte first. Every network byte carries a ninth marker bit. The marker is set on the very first byte of a packet and on its very last byte. The network may raise a caution signal, and the outbound side issues nothing while it is high.

The inbound half collects bytes addressed to this node and reassembles them into 40-bit words. A marked byte opens a packet when no packet is in progress and closes it when one is. Completed words queue for the processor. The block keeps a count of complete packets waiting to be read and holds an interrupt high while that count is non-zero. A packet longer than the outbound store can never finish, so the block reports it as an error and throws that packet away.

Top module: `pw_packet_port`

## Requirements
- R1: Each accepted outbound word leaves as five bytes on `net_tx_data`, bits 39:32 first and bits 7:0 last, each byte valid for exactly one cycle.
- R2: `net_tx_mark` is 1 on the first byte of a packet's first word and on the fifth byte of the word written with `tx_tail`=1; it is 0 on all other bytes.
- R3: No byte of a packet appears on the network before the word carrying `tx_tail`=1 has been accepted.
- R4: If `net_caution` is 1 at a rising clock edge, `net_tx_valid` is 0 in the following cycle; the byte stream resumes without loss or reordering once caution drops.
- R5: `tx_ready` is 0 while the outbound store holds DEPTH_BYTES/5 words, and a word offered then is not taken.
- R6: When the outbound store fills with no complete packet in it, `tx_oversize` pulses for one cycle, the stored words are discarded, `tx_ready` returns to 1, the remaining words of that packet up to and including its tail are dropped, and the next packet is sent intact.
- R7: Five inbound bytes form one word, the first byte landing in bits 39:32; `rx_last` is 1 on a word whose fifth byte carried a mark while a packet was open.
- R8: `rx_irq` is 1 exactly while at least one complete packet has arrived and its last word has not yet been popped; it does not rise before the closing marked byte is accepted.
- R9: `net_rx_ready` is 0 while the inbound store holds DEPTH_BYTES/5 words, and a byte offered then has no effect on later words or packet boundaries.
- R10: After reset `tx_ready` and `net_rx_ready` are 1 while `net_tx_valid`, `tx_oversize`, `rx_valid` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Processor offers an outbound word |
| tx_word | input | 40 | Outbound word |
| tx_tail | input | 1 | Offered word is the last of its packet |
| tx_ready | output | 1 | Outbound word can be taken this cycle |
| tx_oversize | output | 1 | One-cycle pulse: packet exceeded the outbound store |
| net_tx_valid | output | 1 | A network byte is issued this cycle |
| net_tx_data | output | 8 | Issued byte |
| net_tx_mark | output | 1 | Header/trailer marker of the issued byte |
| net_caution | input | 1 | Network asks the port to stop issuing bytes |
| net_rx_valid | input | 1 | Network presents an inbound byte |
| net_rx_data | input | 8 | Inbound byte |
| net_rx_mark | input | 1 | Header/trailer marker of the inbound byte |
| net_rx_ready | output | 1 | Inbound byte can be taken this cycle |
| rx_valid | output | 1 | A reassembled word is available |
| rx_word | output | 40 | Oldest reassembled word |
| rx_last | output | 1 | Oldest word ends its packet |
| rx_pop | input | 1 | Processor consumes the oldest word |
| rx_irq | output | 1 | At least one complete packet is waiting |

## Verification
The bench builds the port with DEPTH_BYTES set to 40, which gives eight-word stores in both directions. With stores that small, a full outbound store, an oversize packet and a full inbound store that must refuse bytes can each be reached with a few dozen words. A queue-based model predicts every output on every cycle, including caution toggled in the middle of a word and a refused marked byte that must not disturb later packet boundaries.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int WORD_W = 40;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic              first;
        logic              tail;
        logic [WORD_W-1:0] word;
    } tx_entry_t;

    typedef struct packed {
        logic              last;
        logic [WORD_W-1:0] word;
    } rx_entry_t;
endpackage

// File: rtl/pw_fifo.sv
module pw_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t s_q, s_d;
    logic [WIDTH-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (push) s_d.wr = step(s_q.wr);
            if (pop)  s_d.rd = step(s_q.rd);
            s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[s_q.wr] <= din;
    end

    assign dout  = mem[s_q.rd];
    assign count = s_q.cnt;
endmodule

// File: rtl/pw_tx_path.sv
module pw_tx_path
    import pw_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_tail,
    output logic              wr_ready,
    output logic              oversize,
    input  logic              caution,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_mark
);
    typedef struct packed {
        logic [CW-1:0]     pkts;
        logic [LANE_W-1:0] idx;
        logic              first_pend;
        logic              discard;
        logic              ovf;
        logic              ov;
        logic [BYTE_W-1:0] od;
        logic              om;
    } tx_state_t;

    tx_state_t s_q, s_d;
    tx_entry_t head, entry;
    logic [CW-1:0] count;
    logic push, pop, flush, full;

    assign entry = '{first: s_q.first_pend, tail: wr_tail, word: wr_word};

    pw_fifo #(.WIDTH($bits(tx_entry_t)), .DEPTH(DEPTH)) i_store (
        .clk(clk), .rst_n(rst_n), .push(push), .din(entry), .pop(pop),
        .flush(flush), .dout(head), .count(count)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ov   = 1'b0;
        s_d.od   = '0;
        s_d.om   = 1'b0;
        s_d.ovf  = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        flush    = 1'b0;
        full     = (count == CW'(DEPTH));
        wr_ready = s_q.discard || !full;
        if (!s_q.discard && full && s_q.pkts == '0) begin
            flush     = 1'b1;
            s_d.discard = 1'b1;
            s_d.ovf   = 1'b1;
            s_d.idx   = '0;
        end else begin
            if (wr_valid && wr_ready) begin
                if (s_q.discard) begin
                    if (wr_tail) begin
                        s_d.discard    = 1'b0;
                        s_d.first_pend = 1'b1;
                    end
                end else begin
                    push           = 1'b1;
                    s_d.first_pend = wr_tail;
                end
            end
            if (s_q.pkts != '0 && !caution) begin
                s_d.ov = 1'b1;
                s_d.od = head.word[(LANES - 1 - int'(s_q.idx)) * BYTE_W +: BYTE_W];
                s_d.om = (s_q.idx == '0 && head.first) ||
                         (s_q.idx == LANE_W'(LANES - 1) && head.tail);
                if (s_q.idx == LANE_W'(LANES - 1)) begin
                    pop     = 1'b1;
                    s_d.idx = '0;
                end else begin
                    s_d.idx = s_q.idx + LANE_W'(1);
                end
            end
            s_d.pkts = s_q.pkts + CW'(push && wr_tail) - CW'(pop && head.tail);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.first_pend <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign oversize  = s_q.ovf;
    assign out_valid = s_q.ov;
    assign out_data  = s_q.od;
    assign out_mark  = s_q.om;
endmodule

// File: rtl/pw_rx_path.sv
module pw_rx_path
    import pw_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_mark,
    output logic              in_ready,
    input  logic              rd_pop,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_last,
    output logic              irq
);
    typedef struct packed {
        logic [WORD_W-BYTE_W-1:0] acc;
        logic [LANE_W-1:0]        cnt;
        logic                     open;
        logic [CW-1:0]            pkts;
    } rx_state_t;

    rx_state_t s_q, s_d;
    rx_entry_t head, entry;
    logic [CW-1:0] count;
    logic push, pop, take;

    pw_fifo #(.WIDTH($bits(rx_entry_t)), .DEPTH(DEPTH)) i_store (
        .clk(clk), .rst_n(rst_n), .push(push), .din(entry), .pop(pop),
        .flush(1'b0), .dout(head), .count(count)
    );

    always_comb begin
        s_d      = s_q;
        in_ready = (count != CW'(DEPTH));
        take     = in_valid && in_ready;
        pop      = rd_pop && (count != '0);
        push     = 1'b0;
        entry    = '{last: in_mark && s_q.open, word: {s_q.acc, in_data}};
        if (take) begin
            if (s_q.cnt == LANE_W'(LANES - 1)) begin
                push    = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + LANE_W'(1);
                s_d.acc = {s_q.acc[WORD_W-2*BYTE_W-1:0], in_data};
            end
            if (in_mark) s_d.open = !s_q.open;
        end
        s_d.pkts = s_q.pkts + CW'(push && entry.last) - CW'(pop && head.last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid = (count != '0);
    assign rd_word  = head.word;
    assign rd_last  = head.last;
    assign irq      = (s_q.pkts != '0);
endmodule

// File: rtl/pw_packet_port.sv
module pw_packet_port
    import pw_pkg::*;
#(
    parameter int DEPTH_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_tail,
    output logic              tx_ready,
    output logic              tx_oversize,
    output logic              net_tx_valid,
    output logic [BYTE_W-1:0] net_tx_data,
    output logic              net_tx_mark,
    input  logic              net_caution,
    input  logic              net_rx_valid,
    input  logic [BYTE_W-1:0] net_rx_data,
    input  logic              net_rx_mark,
    output logic              net_rx_ready,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_last,
    input  logic              rx_pop,
    output logic              rx_irq
);
    localparam int WORD_DEPTH = DEPTH_BYTES / LANES;

    pw_tx_path #(.DEPTH(WORD_DEPTH)) i_tx (
        .clk(clk), .rst_n(rst_n), .wr_valid(tx_valid), .wr_word(tx_word),
        .wr_tail(tx_tail), .wr_ready(tx_ready), .oversize(tx_oversize),
        .caution(net_caution), .out_valid(net_tx_valid),
        .out_data(net_tx_data), .out_mark(net_tx_mark)
    );

    pw_rx_path #(.DEPTH(WORD_DEPTH)) i_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(net_rx_valid),
        .in_data(net_rx_data), .in_mark(net_rx_mark), .in_ready(net_rx_ready),
        .rd_pop(rx_pop), .rd_valid(rx_valid), .rd_word(rx_word),
        .rd_last(rx_last), .irq(rx_irq)
    );
endmodule

// File: rtl/pw_packet_port_chk.sv
module pw_packet_port_chk
    import pw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic [WORD_W-1:0] tx_word,
    input logic              tx_tail,
    input logic              tx_ready,
    input logic              tx_oversize,
    input logic              net_tx_valid,
    input logic [BYTE_W-1:0] net_tx_data,
    input logic              net_tx_mark,
    input logic              net_caution,
    input logic              net_rx_valid,
    input logic [BYTE_W-1:0] net_rx_data,
    input logic              net_rx_mark,
    input logic              net_rx_ready,
    input logic              rx_valid,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_last,
    input logic              rx_pop,
    input logic              rx_irq
);
    logic tail_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                tail_seen_q <= 1'b0;
        else if (tx_valid && tx_ready && tx_tail)  tail_seen_q <= 1'b1;
    end

    a_r3_no_byte_before_tail: assert property (@(posedge clk) disable iff (!rst_n)
        net_tx_valid |-> tail_seen_q);

    a_r4_caution_silences: assert property (@(posedge clk) disable iff (!rst_n)
        $past(net_caution) |-> !net_tx_valid);

    a_r6_oversize_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oversize |-> (tx_ready && $past(!tx_ready)));

    a_r8_irq_rise_on_trailer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(net_rx_valid && net_rx_ready && net_rx_mark));

    a_r8_irq_fall_on_last_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_irq) |-> $past(rx_pop && rx_valid && rx_last));

    a_r9_refuse_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        !net_rx_ready |-> rx_valid);
endmodule

bind pw_packet_port pw_packet_port_chk i_chk (.*);

// File: tb/test_pw_packet_port.sv
module test_pw_packet_port;
    localparam int DB = 40;
    localparam int WD = DB / 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_valid = 1'b0, tx_tail = 1'b0, net_caution = 1'b0;
    logic [39:0] tx_word = '0;
    logic net_rx_valid = 1'b0, net_rx_mark = 1'b0, rx_pop = 1'b0;
    logic [7:0] net_rx_data = '0;
    logic tx_ready, tx_oversize, net_tx_valid, net_tx_mark, net_rx_ready;
    logic rx_valid, rx_last, rx_irq;
    logic [7:0] net_tx_data;
    logic [39:0] rx_word;

    pw_packet_port #(.DEPTH_BYTES(DB)) i_pw_packet_port (.*);

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0, tx_seen = 0;
    bit done = 0;

    typedef struct { bit first; bit tail; bit [39:0] w; } te_t;
    typedef struct { bit last; bit [39:0] w; } re_t;
    te_t txq[$];
    re_t rxq[$];
    int  m_txp, m_idx, m_rxp, m_cnt;
    bit  m_fp, m_disc, m_ovf, m_ov, m_om, m_inp;
    bit [7:0]  m_od;
    bit [31:0] m_acc;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // reference model, one update per rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_txp = 0; m_idx = 0; m_rxp = 0; m_cnt = 0; m_fp = 1; m_disc = 0;
            m_ovf = 0; m_ov = 0; m_om = 0; m_od = 0; m_inp = 0; m_acc = 0;
        end else begin
            bit full, rdy, rrdy;
            te_t h;
            re_t r;
            full = (txq.size() == WD);
            rdy  = m_disc || !full;
            m_ov = 0; m_od = 0; m_om = 0; m_ovf = 0;
            if (!m_disc && full && m_txp == 0) begin
                txq.delete(); m_disc = 1; m_ovf = 1; m_idx = 0;
            end else begin
                if (m_txp > 0 && !net_caution) begin
                    h = txq[0];
                    m_ov = 1;
                    m_od = h.w[(4 - m_idx) * 8 +: 8];
                    m_om = (m_idx == 0 && h.first) || (m_idx == 4 && h.tail);
                    if (m_idx == 4) begin
                        void'(txq.pop_front());
                        if (h.tail) m_txp--;
                        m_idx = 0;
                    end else m_idx++;
                end
                if (tx_valid && rdy) begin
                    if (m_disc) begin
                        if (tx_tail) begin m_disc = 0; m_fp = 1; end
                    end else begin
                        txq.push_back('{m_fp, tx_tail, tx_word});
                        m_fp = tx_tail;
                        if (tx_tail) m_txp++;
                    end
                end
            end
            rrdy = (rxq.size() < WD);
            if (rx_pop && rxq.size() > 0) begin
                r = rxq.pop_front();
                if (r.last) m_rxp--;
            end
            if (net_rx_valid && rrdy) begin
                if (m_cnt == 4) begin
                    r = '{net_rx_mark && m_inp, {m_acc, net_rx_data}};
                    rxq.push_back(r);
                    if (r.last) m_rxp++;
                    m_cnt = 0;
                end else begin
                    m_acc = {m_acc[23:0], net_rx_data};
                    m_cnt++;
                end
                if (net_rx_mark) m_inp = !m_inp;
            end
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (net_tx_valid) tx_seen++;
            chk("R1", "net_tx_valid", net_tx_valid, m_ov);
            if (m_ov) begin
                chk("R1", "net_tx_data", net_tx_data, m_od);
                chk("R2", "net_tx_mark", net_tx_mark, m_om);
            end
            chk("R5", "tx_ready", tx_ready, m_disc || txq.size() < WD);
            chk("R6", "tx_oversize", tx_oversize, m_ovf);
            chk("R9", "net_rx_ready", net_rx_ready, rxq.size() < WD);
            chk("R7", "rx_valid", rx_valid, rxq.size() > 0);
            if (rxq.size() > 0) begin
                chk("R7", "rx_word", rx_word, rxq[0].w);
                chk("R7", "rx_last", rx_last, rxq[0].last);
            end
            chk("R8", "rx_irq", rx_irq, m_rxp != 0);
        end
    end

    task automatic put(input bit [39:0] w, input bit t);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1; tx_word = w; tx_tail = t;
        @(negedge clk);
        tx_valid = 0; tx_tail = 0;
    endtask

    task automatic give(input bit [7:0] b, input bit m);
        while (!net_rx_ready) @(negedge clk);
        net_rx_valid = 1; net_rx_data = b; net_rx_mark = m;
        @(negedge clk);
        net_rx_valid = 0; net_rx_mark = 0;
    endtask

    task automatic give_pkt(input int nw, input bit [39:0] base);
        for (int i = 0; i < nw; i++)
            for (int k = 0; k < 5; k++)
                give(8'((base + 40'(i)) >> ((4 - k) * 8)),
                     (i == 0 && k == 0) || (i == nw - 1 && k == 4));
    endtask

    task automatic take(output bit [39:0] w, output bit l);
        while (!rx_valid) @(negedge clk);
        w = rx_word; l = rx_last;
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        int base;
        bit [39:0] w;
        bit l;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "tx_ready", tx_ready, 1);
        chk("R10", "net_rx_ready", net_rx_ready, 1);
        chk("R10", "net_tx_valid", net_tx_valid, 0);
        chk("R10", "tx_oversize", tx_oversize, 0);
        chk("R10", "rx_valid", rx_valid, 0);
        chk("R10", "rx_irq", rx_irq, 0);

        // R3: nothing leaves before the tail word
        base = tx_seen;
        put(40'h11_2233_4455, 0);
        put(40'h66_7788_99AA, 0);
        idle(12);
        chk("R3", "bytes before tail", tx_seen - base, 0);
        put(40'hBB_CCDD_EEFF, 1);
        idle(20);
        chk("R1", "bytes of 3-word packet", tx_seen - base, 15);

        // single-word packet, marks on both ends (R2)
        base = tx_seen;
        put(40'hA5_5A0F_F0C3, 1);
        idle(10);
        chk("R2", "bytes of 1-word packet", tx_seen - base, 5);

        // R4: caution held, then released
        net_caution = 1;
        base = tx_seen;
        put(40'h01_0203_0405, 0);
        put(40'h06_0708_090A, 1);
        idle(10);
        chk("R4", "bytes under caution", tx_seen - base, 0);
        net_caution = 0;
        idle(15);
        chk("R4", "bytes after caution", tx_seen - base, 10);

        // R4: caution toggled mid-word
        base = tx_seen;
        for (int i = 0; i < 4; i++) put(40'hC0_0000_0000 + 40'(i * 3), i == 3);
        for (int i = 0; i < 30; i++) begin
            net_caution = (i % 3) != 0;
            @(negedge clk);
        end
        net_caution = 0;
        idle(20);
        chk("R4", "bytes with toggled caution", tx_seen - base, 20);

        // R5: outbound store full
        net_caution = 1;
        for (int i = 0; i < WD; i++) put(40'hD0_0000_0100 + 40'(i), i == WD - 1);
        chk("R5", "tx_ready when full", tx_ready, 0);
        base = tx_seen;
        net_caution = 0;
        idle(50);
        chk("R5", "bytes after full drain", tx_seen - base, WD * 5);

        // R6: oversize packet
        base = tx_seen;
        for (int i = 0; i < WD; i++) put(40'hE0_0000_0000 + 40'(i), 0);
        @(negedge clk);
        chk("R6", "tx_oversize pulse", tx_oversize, 1);
        put(40'hE1_0000_0001, 0);
        put(40'hE1_0000_0002, 0);
        put(40'hE1_0000_0003, 1);
        put(40'hF0_1234_5678, 0);
        put(40'hF1_9ABC_DEF0, 1);
        idle(20);
        chk("R6", "bytes after oversize", tx_seen - base, 10);

        // R7 and R8: inbound packet
        give_pkt(1, 40'h12_3456_789A);
        chk("R8", "irq after 1-word packet", rx_irq, 1);
        take(w, l);
        chk("R7", "word", w, 40'h12_3456_789A);
        chk("R7", "last", l, 1);
        chk("R8", "irq after read", rx_irq, 0);
        for (int k = 0; k < 9; k++)
            give(8'h30 + 8'(k), k == 0);
        chk("R8", "irq before trailer", rx_irq, 0);
        give(8'h39, 1);
        chk("R8", "irq after trailer", rx_irq, 1);
        take(w, l);
        chk("R7", "first word of 2", w, 40'h30_3132_3334);
        chk("R8", "irq mid-packet read", rx_irq, 1);
        take(w, l);
        chk("R7", "trailer word", l, 1);
        chk("R8", "irq cleared", rx_irq, 0);

        // R9: inbound store full, extra marked byte refused
        give_pkt(4, 40'h40_0000_0000);
        give_pkt(4, 40'h50_0000_0000);
        chk("R9", "net_rx_ready when full", net_rx_ready, 0);
        net_rx_valid = 1; net_rx_data = 8'hEE; net_rx_mark = 1;
        @(negedge clk);
        net_rx_valid = 0; net_rx_mark = 0;
        for (int i = 0; i < 8; i++) take(w, l);
        give_pkt(2, 40'h77_0000_0000);
        take(w, l);
        chk("R9", "word after refused byte", w, 40'h77_0000_0000);
        chk("R9", "no early boundary", l, 0);
        take(w, l);
        chk("R9", "boundary after refused byte", l, 1);
        chk("R8", "irq after all read", rx_irq, 0);

        // both directions at once, back-to-back inbound packets
        fork
            begin
                put(40'h9A_0000_0001, 0);
                put(40'h9A_0000_0002, 1);
            end
            begin
                give_pkt(1, 40'h88_0000_0001);
                give_pkt(1, 40'h88_0000_0002);
            end
        join
        take(w, l);
        chk("R8", "irq with one packet left", rx_irq, 1);
        take(w, l);
        chk("R7", "second packet word", w, 40'h88_0000_0002);
        idle(20);
        finish_run();
    end
endmodule